// File: doc/BRIEF.md
# Floating-Point NaN Screen

This unit inspects one floating-point word and tells whether it holds a NaN. If it does, the unit says whether that NaN is quiet or signaling. The word can be in half, bfloat16, single or double format, chosen per operation. Two run-time policy inputs control how NaNs are read. One inverts the meaning of the top fraction bit. The other turns off signaling NaNs, so every NaN counts as quiet.

Next to the flags, the unit gives two words. The first is the input with a signaling NaN made quiet. The second is the canonical NaN for the chosen format and policy. Arithmetic datapaths use it at the operand-screening step. The sign of the word never changes the classification. An optional register stage, on by default, retimes all outputs by one clock.

Top module: `nan_screen`

## Requirements
- R1: `fmt_sel` chooses the format: 2'b00 half (exponent bits 14:10, fraction 9:0), 2'b01 bfloat16 (exponent 14:7, fraction 6:0), 2'b10 single (exponent 30:23, fraction 22:0), 2'b11 double (exponent 62:52, fraction 51:0). `is_nan` is 1 when the exponent field is all ones and the fraction is nonzero. Input bits above the format width are ignored.
- R2: The sign bit (the top bit of the format) never affects `is_nan`, `is_qnan` or `is_snan`.
- R3: With `sig_pol`=0 and `no_snan_mode`=0, a NaN whose top fraction bit is 1 raises `is_qnan`. A NaN whose top fraction bit is 0 raises `is_snan`. The two flags are never both 1.
- R4: With `sig_pol`=1 and `no_snan_mode`=0, the two cases swap: top fraction bit 0 means quiet and 1 means signaling.
- R5: With `no_snan_mode`=1, `is_snan` is 0 and every NaN raises `is_qnan`, whatever `sig_pol` is.
- R6: For a signaling NaN with `sig_pol`=0, `quiet_out` is the input with the top fraction bit set.
- R7: For a signaling NaN with `sig_pol`=1, `quiet_out` is the input with the top fraction bit cleared and the fraction bit just below it set.
- R8: For any input that is not a signaling NaN, `quiet_out` equals the input, sign included. In all cases bits of `quiet_out` above the format width are 0.
- R9: `dflt_out` has sign 0 and an all-ones exponent. Its fraction is only the top bit when `sig_pol`=0, and all bits except the top one when `sig_pol`=1. Examples: half 16'h7E00/16'h7DFF, bfloat16 16'h7FC0/16'h7FBF, single 32'h7FC00000/32'h7FBFFFFF, double 64'h7FF8000000000000/64'h7FF7FFFFFFFFFFFF.
- R10: With `REG_OUT`=1, each output shows the result of the inputs present at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| fmt_sel | input | 2 | Format select |
| sig_pol | input | 1 | Signaling-bit polarity, 0 means top fraction bit set is quiet |
| no_snan_mode | input | 1 | Treat all NaNs as quiet |
| din | input | 64 | Word to inspect, narrow formats in the low bits |
| is_nan | output | 1 | Input is a NaN of any kind |
| is_qnan | output | 1 | Input is a quiet NaN |
| is_snan | output | 1 | Input is a signaling NaN |
| quiet_out | output | 64 | Input with a signaling NaN quieted |
| dflt_out | output | 64 | Default NaN for the format and policy |

## Verification
The checker keeps its own copy of `din` and `no_snan_mode`, delayed to match the output latency. It therefore assumes that the `REG_OUT` setting seen by the bind matches the instance, and that reset clears that copy along with the outputs. The bench holds every input steady from one falling edge to the next, so each result depends on one input set only. It reads the outputs at the falling edge after the capturing rising edge. The stimulus uses zero, infinity, quiet and signaling encodings with both signs in all four formats. It covers each policy combination and also drives junk in the unused upper bits.

// File: rtl/nan_screen.sv
module nan_screen #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt_sel,
  input  logic        sig_pol,
  input  logic        no_snan_mode,
  input  logic [63:0] din,
  output logic        is_nan,
  output logic        is_qnan,
  output logic        is_snan,
  output logic [63:0] quiet_out,
  output logic [63:0] dflt_out
);
  localparam logic [6:0] HALF_F = 7'd10, HALF_E = 7'd5;
  localparam logic [6:0] BF_F   = 7'd7,  BF_E   = 7'd8;
  localparam logic [6:0] SGL_F  = 7'd23, SGL_E  = 7'd8;
  localparam logic [6:0] DBL_F  = 7'd52, DBL_E  = 7'd11;

  logic [6:0]  fw, ew;
  logic [63:0] fmask, emask, wmask, top, expo, frac;
  logic        nan_c, msb_c, snan_c, qnan_c;
  logic [63:0] quiet_c, dflt_c;

  always_comb begin
    case (fmt_sel)
      2'b00:   begin fw = HALF_F; ew = HALF_E; end
      2'b01:   begin fw = BF_F;   ew = BF_E;   end
      2'b10:   begin fw = SGL_F;  ew = SGL_E;  end
      default: begin fw = DBL_F;  ew = DBL_E;  end
    endcase
  end

  assign fmask = (64'd1 << fw) - 64'd1;
  assign emask = (64'd1 << ew) - 64'd1;
  assign wmask = (64'd1 << (fw + ew + 7'd1)) - 64'd1;
  assign top   = 64'd1 << (fw - 7'd1);
  assign expo  = (din >> fw) & emask;
  assign frac  = din & fmask;

  assign nan_c  = (expo == emask) && (frac != 64'd0);
  assign msb_c  = (din & top) != 64'd0;
  assign snan_c = nan_c && !no_snan_mode && (msb_c == sig_pol);
  assign qnan_c = nan_c && !snan_c;

  always_comb begin
    if (!snan_c)     quiet_c = din & wmask;
    else if (sig_pol) quiet_c = ((din & ~top) | (top >> 1)) & wmask;
    else              quiet_c = (din | top) & wmask;
  end

  assign dflt_c = (emask << fw) | (sig_pol ? (fmask & ~top) : top);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          is_nan    <= 1'b0;
          is_qnan   <= 1'b0;
          is_snan   <= 1'b0;
          quiet_out <= 64'd0;
          dflt_out  <= 64'd0;
        end else begin
          is_nan    <= nan_c;
          is_qnan   <= qnan_c;
          is_snan   <= snan_c;
          quiet_out <= quiet_c;
          dflt_out  <= dflt_c;
        end
      end
    end else begin : g_comb
      assign is_nan    = nan_c;
      assign is_qnan   = qnan_c;
      assign is_snan   = snan_c;
      assign quiet_out = quiet_c;
      assign dflt_out  = dflt_c;
    end
  endgenerate
endmodule

// File: rtl/nan_screen_chk.sv
module nan_screen_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        no_snan_mode,
  input logic [63:0] din,
  input logic        is_nan,
  input logic        is_qnan,
  input logic        is_snan,
  input logic [63:0] quiet_out,
  input logic [63:0] dflt_out
);
  logic        ns_d;
  logic [63:0] din_d;

  generate
    if (REG_OUT) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ns_d  <= 1'b0;
          din_d <= 64'd0;
        end else begin
          ns_d  <= no_snan_mode;
          din_d <= din;
        end
      end
    end else begin : g_pass
      assign ns_d  = no_snan_mode;
      assign din_d = din;
    end
  endgenerate

  // R3
  q_s_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_qnan, is_snan}));

  // R1
  nan_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nan |-> (is_qnan || is_snan));

  // R1
  kind_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_qnan || is_snan) |-> is_nan);

  // R5
  no_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_d |-> !is_snan);

  // R6
  quiet_alters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_snan |-> (quiet_out != din_d));

  // R9
  dflt_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dflt_out[63]);
endmodule

bind nan_screen nan_screen_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .no_snan_mode(no_snan_mode), .din(din),
  .is_nan(is_nan), .is_qnan(is_qnan), .is_snan(is_snan),
  .quiet_out(quiet_out), .dflt_out(dflt_out)
);

// File: tb/nan_screen_test.sv
module nan_screen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        sig_pol = 1'b0;
  logic        no_snan_mode = 1'b0;
  logic [63:0] din = 64'd0;
  logic        is_nan, is_qnan, is_snan;
  logic [63:0] quiet_out, dflt_out;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nan_screen uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sig_pol(sig_pol),
    .no_snan_mode(no_snan_mode), .din(din), .is_nan(is_nan),
    .is_qnan(is_qnan), .is_snan(is_snan), .quiet_out(quiet_out),
    .dflt_out(dflt_out)
  );

  // {fmt, pol, nosnan, din, nan, q, s, quieted}
  localparam int NV = 23;
  localparam logic [134:0] VEC [NV] = '{
    {2'b00,1'b0,1'b0,64'h7E00,3'b110,64'h7E00},
    {2'b00,1'b0,1'b0,64'h7C01,3'b101,64'h7E01},
    {2'b00,1'b0,1'b0,64'h7C00,3'b000,64'h7C00},
    {2'b00,1'b0,1'b0,64'hFE00,3'b110,64'hFE00},
    {2'b00,1'b1,1'b0,64'h7E00,3'b101,64'h7D00},
    {2'b00,1'b1,1'b0,64'h7C01,3'b110,64'h7C01},
    {2'b00,1'b0,1'b1,64'h7C01,3'b110,64'h7C01},
    {2'b00,1'b0,1'b0,64'hFFFF_0000_0000_3C00,3'b000,64'h3C00},
    {2'b01,1'b0,1'b0,64'h7FC0,3'b110,64'h7FC0},
    {2'b01,1'b0,1'b0,64'h7F81,3'b101,64'h7FC1},
    {2'b01,1'b1,1'b0,64'h7FC1,3'b101,64'h7FA1},
    {2'b01,1'b0,1'b0,64'hFF80,3'b000,64'hFF80},
    {2'b10,1'b0,1'b0,64'h7FC0_0000,3'b110,64'h7FC0_0000},
    {2'b10,1'b0,1'b0,64'h7F80_0001,3'b101,64'h7FC0_0001},
    {2'b10,1'b0,1'b0,64'h7F80_0000,3'b000,64'h7F80_0000},
    {2'b10,1'b1,1'b0,64'h7FC0_0000,3'b101,64'h7FA0_0000},
    {2'b10,1'b0,1'b1,64'hFF80_0001,3'b110,64'hFF80_0001},
    {2'b10,1'b0,1'b0,64'h3F80_0000,3'b000,64'h3F80_0000},
    {2'b11,1'b0,1'b0,64'h7FF8_0000_0000_0000,3'b110,64'h7FF8_0000_0000_0000},
    {2'b11,1'b0,1'b0,64'h7FF0_0000_0000_0001,3'b101,64'h7FF8_0000_0000_0001},
    {2'b11,1'b1,1'b0,64'hFFF8_0000_0000_0000,3'b101,64'hFFF4_0000_0000_0000},
    {2'b11,1'b0,1'b0,64'h7FF0_0000_0000_0000,3'b000,64'h7FF0_0000_0000_0000},
    {2'b11,1'b1,1'b1,64'h7FF8_0000_0000_0000,3'b110,64'h7FF8_0000_0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic p, input logic ns, input logic [63:0] d);
    @(negedge clk);
    fmt_sel = f; sig_pol = p; no_snan_mode = ns; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] dflt_exp(input logic [1:0] f, input logic p);
    case ({f, p})
      3'b000: return 64'h7E00;
      3'b001: return 64'h7DFF;
      3'b010: return 64'h7FC0;
      3'b011: return 64'h7FBF;
      3'b100: return 64'h7FC0_0000;
      3'b101: return 64'h7FBF_FFFF;
      3'b110: return 64'h7FF8_0000_0000_0000;
      default: return 64'h7FF7_FFFF_FFFF_FFFF;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: outputs held at zero in reset despite a NaN on the input
    din = 64'h7C01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset flags", {61'd0, is_nan, is_qnan, is_snan}, 64'd0);
    chk("R10 reset quiet", quiet_out, 64'd0);
    chk("R10 reset dflt", dflt_out, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [134:0] v;
      string cls_tag, q_tag;
      v = VEC[i];
      apply(v[134:133], v[132], v[131], v[130:67]);
      cls_tag = v[131] ? "R5" : (v[132] ? "R4" : "R3");
      q_tag = v[64] ? (v[132] ? "R7" : "R6") : "R8";
      chk("R1/R2 is_nan", {63'd0, is_nan}, {63'd0, v[66]});
      chk(cls_tag, {62'd0, is_qnan, is_snan}, {62'd0, v[65], v[64]});
      chk(q_tag, quiet_out, v[63:0]);
    end

    // R9: default NaN for every format and polarity, both no-snan settings
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 2; p++) begin
        apply(f[1:0], p[0], f[0], 64'd0);
        chk("R9 default", dflt_out, dflt_exp(f[1:0], p[0]));
      end
    end

    // R10: one-cycle latency, new input not visible before the edge
    apply(2'b10, 1'b0, 1'b0, 64'h7F80_0001);
    @(negedge clk);
    din = 64'h0;
    #1;
    chk("R10 hold", {63'd0, is_snan}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 update", {63'd0, is_nan}, 64'd0);

    // R2: sign flip on a signaling single keeps the class
    apply(2'b10, 1'b0, 1'b0, 64'hFF80_0001);
    chk("R2 neg snan", {62'd0, is_qnan, is_snan}, 64'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule